// File: doc/BRIEF.md
# Three-Wire Synthesizer Programming Port

This block receives configuration words for a frequency synthesizer over three wires: serial data, serial clock and load enable. All three pins are asynchronous to the system clock. Each is brought through a synchronizer chain before use. Every rising edge of the serial clock pushes one data bit into a shared 19-bit shift register, most significant bit first.

A rising edge on load enable commits the shifted word. The last bit shifted in is the steering bit, and it picks one of two holding registers. If the steering bit is 1, the word goes to the reference register. That register holds the 14-bit reference ratio and three mode bits: prescaler modulus select, phase-detector polarity and lock-detect output select. If the steering bit is 0, the word goes to the divider register. That register holds a 7-bit swallow count and an 11-bit main count. The decoded fields are driven in parallel to the divider and phase-detector logic. Each commit is followed by a one-cycle strobe that identifies which register was written.

Control is a three-state machine.
- **ST_IDLE**: serial clocks shift bits in. The transition **ST_IDLE→ST_COMMIT** is taken on a synchronized rising edge of load enable.
- **ST_COMMIT**: lasts one cycle and writes the selected register. The transition **ST_COMMIT→ST_HOLD** is unconditional.
- **ST_HOLD**: waits with shifting frozen. The transition **ST_HOLD→ST_IDLE** is taken once load enable is seen low.

Top module: `synth_prog_port`

## Requirements
- R1: After reset all field outputs are zero and both strobes are low.
- R2: One bit enters per serial-clock rising edge, most significant bit first, so the last bit shifted in sits at word bit 0, the steering bit.
- R3: A commit with steering bit 1 loads the reference register from the low 18 shifted positions: bits 14:1 give the reference ratio (valid range 5 to 16383), bit 15 gives the prescaler select, bit 16 the phase polarity and bit 17 the lock-detect select.
- R4: A commit with steering bit 0 loads the divider register: bits 7:1 give the swallow count (0 to 127) and bits 18:8 give the main count (5 to 2047).
- R5: Register outputs change only on a commit and only in the register chosen. Shifting a new word with load enable low leaves every output unchanged.
- R6: Each commit raises exactly one strobe, the one matching the written register, for exactly one system-clock cycle.
- R7: Serial-clock edges that arrive while load enable is high, or before it has been seen low again, are ignored. A second commit without new bits reloads the same word.
- R8: For a reference word, any bit shifted in before its 18 bits (shift position 18) has no effect on the reference fields.
- R9: With the default two-stage synchronizers, the strobe and the new fields appear on the fourth system-clock edge after load enable rises at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial data pin |
| ser_clk | input | 1 | Serial clock pin, sampled on rising edge |
| ser_le | input | 1 | Load enable pin, commits on rising edge |
| ref_ratio | output | 14 | Reference divide ratio |
| presc_sel | output | 1 | Prescaler modulus select |
| pd_polarity | output | 1 | Phase-detector polarity |
| ld_sel | output | 1 | Lock-detect output select |
| ref_valid | output | 1 | One-cycle strobe after reference register write |
| swallow | output | 7 | Swallow count |
| main_cnt | output | 11 | Main divide count |
| div_valid | output | 1 | One-cycle strobe after divider register write |

## Verification
Reference words are driven for all eight mode-bit combinations, with ratios at 5, at 16383 and at pseudo-random values between them. A swapped or shifted field shows up as a wrong mode bit or a wrong ratio value. Divider words cover the extremes of the swallow and main counts plus pseudo-random interior values, and are interleaved with reference words. This exposes steering errors and any write that leaks into the wrong register. Further cases separate frozen from active shifting:
- words shifted without a commit;
- serial clocks toggled while load enable is high, followed by a bare re-commit;
- a leading stray bit ahead of a reference word.

Each commit is also timed against the fixed synchronizer latency.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_HOLD   = 2'd2
    } port_state_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= pin;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], pin};
            end
        end
    endgenerate

    assign level = chain[STAGES-1];
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
    parameter int W = 19
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int REF_W       = 14,
    parameter int SWAL_W      = 7,
    parameter int MAIN_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_data,
    input  logic              ser_clk,
    input  logic              ser_le,
    output logic [REF_W-1:0]  ref_ratio,
    output logic              presc_sel,
    output logic              pd_polarity,
    output logic              ld_sel,
    output logic              ref_valid,
    output logic [SWAL_W-1:0] swallow,
    output logic [MAIN_W-1:0] main_cnt,
    output logic              div_valid
);
    localparam int SR_W   = 1 + SWAL_W + MAIN_W;
    localparam int POS_SW = REF_W + 1;
    localparam int POS_FC = REF_W + 2;
    localparam int POS_LD = REF_W + 3;
    localparam int POS_N  = SWAL_W + 1;

    logic data_lvl, sclk_lvl, le_lvl;
    logic sclk_prev, le_prev;
    logic sclk_rise, le_rise;
    logic shift_en;
    logic [SR_W-1:0] sr_q;
    port_state_t st, st_nx;

    pin_sync #(.STAGES(SYNC_STAGES)) u_sync_data (.clk(clk), .rst_n(rst_n), .pin(ser_data), .level(data_lvl));
    pin_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (.clk(clk), .rst_n(rst_n), .pin(ser_clk),  .level(sclk_lvl));
    pin_sync #(.STAGES(SYNC_STAGES)) u_sync_le   (.clk(clk), .rst_n(rst_n), .pin(ser_le),   .level(le_lvl));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            le_prev   <= 1'b0;
        end else begin
            sclk_prev <= sclk_lvl;
            le_prev   <= le_lvl;
        end
    end

    assign sclk_rise = sclk_lvl & ~sclk_prev;
    assign le_rise   = le_lvl & ~le_prev;
    assign shift_en  = (st == ST_IDLE) && sclk_rise;

    ser_shift #(.W(SR_W)) u_shift (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (shift_en),
        .din  (data_lvl),
        .q    (sr_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (le_rise) st_nx = ST_COMMIT;
            ST_COMMIT: st_nx = ST_HOLD;
            ST_HOLD:   if (!le_lvl) st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // outputs: holding registers and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ratio   <= '0;
            presc_sel   <= 1'b0;
            pd_polarity <= 1'b0;
            ld_sel      <= 1'b0;
            swallow     <= '0;
            main_cnt    <= '0;
            ref_valid   <= 1'b0;
            div_valid   <= 1'b0;
        end else begin
            ref_valid <= 1'b0;
            div_valid <= 1'b0;
            if (st == ST_COMMIT) begin
                if (sr_q[0]) begin
                    ref_ratio   <= sr_q[REF_W:1];
                    presc_sel   <= sr_q[POS_SW];
                    pd_polarity <= sr_q[POS_FC];
                    ld_sel      <= sr_q[POS_LD];
                    ref_valid   <= 1'b1;
                end else begin
                    swallow   <= sr_q[SWAL_W:1];
                    main_cnt  <= sr_q[SR_W-1:POS_N];
                    div_valid <= 1'b1;
                end
            end
        end
    end

    AST_VALID_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(ref_valid && div_valid)); // R6
    AST_REF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> !ref_valid); // R6
    AST_DIV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |=> !div_valid); // R6
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |-> $stable({ref_ratio, presc_sel, pd_polarity, ld_sel})); // R5
    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !div_valid |-> $stable({swallow, main_cnt})); // R5
    AST_NO_SHIFT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> $stable(sr_q)); // R7
    AST_REF_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> $past(sr_q[0])); // R3
    AST_DIV_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        div_valid |-> !$past(sr_q[0])); // R4
endmodule

// File: tb/sim_synth_prog_port.sv
module sim_synth_prog_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, ser_clk = 1'b0, ser_le = 1'b0;
    logic [13:0] ref_ratio;
    logic presc_sel, pd_polarity, ld_sel, ref_valid, div_valid;
    logic [6:0] swallow;
    logic [10:0] main_cnt;

    int n_chk = 0;
    int n_err = 0;
    int ref_pulses = 0;
    int div_pulses = 0;
    logic [31:0] lcg = 32'h1234_5677;

    // expected register contents
    logic [13:0] e_ratio = '0;
    logic [2:0]  e_mode = '0;
    logic [6:0]  e_a = '0;
    logic [10:0] e_n = '0;

    always #2 clk = ~clk;

    synth_prog_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
        .ref_ratio(ref_ratio), .presc_sel(presc_sel), .pd_polarity(pd_polarity), .ld_sel(ld_sel),
        .ref_valid(ref_valid), .swallow(swallow), .main_cnt(main_cnt), .div_valid(div_valid)
    );

    always @(posedge clk) begin
        if (ref_valid) ref_pulses <= ref_pulses + 1;
        if (div_valid) div_pulses <= div_pulses + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    task automatic send_bits(input logic [18:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            wait_neg(3);
            ser_clk = 1'b1;
            wait_neg(3);
            ser_clk = 1'b0;
            wait_neg(2);
        end
    endtask

    task automatic check_fields(input string req);
        chk({req, " ratio"}, 32'(ref_ratio), 32'(e_ratio));
        chk({req, " mode"}, 32'({ld_sel, pd_polarity, presc_sel}), 32'(e_mode));
        chk({req, " swallow"}, 32'(swallow), 32'(e_a));
        chk({req, " main"}, 32'(main_cnt), 32'(e_n));
    endtask

    // raise load enable, time the strobe, check its width and identity
    task automatic commit(input logic expect_ref, input logic extra_clocks);
        int k;
        int rp0, dp0;
        rp0 = ref_pulses;
        dp0 = div_pulses;
        ser_le = 1'b1;
        k = 0;
        for (int j = 1; j <= 10; j++) begin
            @(negedge clk);
            if (ref_valid || div_valid) begin
                k = j;
                break;
            end
        end
        chk("R9 strobe latency", 32'(k), 32'd4);
        chk("R6 strobe identity", 32'({ref_valid, div_valid}), expect_ref ? 32'd2 : 32'd1);
        @(negedge clk);
        chk("R6 strobe width", 32'({ref_valid, div_valid}), 32'd0);
        if (extra_clocks) send_bits(19'h7FFFF, 3);
        ser_le = 1'b0;
        wait_neg(6);
        chk("R6 ref pulse count", 32'(ref_pulses - rp0), expect_ref ? 32'd1 : 32'd0);
        chk("R6 div pulse count", 32'(div_pulses - dp0), expect_ref ? 32'd0 : 32'd1);
    endtask

    task automatic do_ref(input logic [13:0] r, input logic [2:0] m, input logic lead);
        logic [18:0] w;
        w = {lead, m[2], m[1], m[0], r, 1'b1};
        send_bits(w, 19);
        check_fields("R5 no change before commit");
        e_ratio = r;
        e_mode = m;
        commit(1'b1, 1'b0);
        check_fields("R3 reference word");
    endtask

    task automatic do_div(input logic [6:0] a, input logic [10:0] n);
        send_bits({n, a, 1'b0}, 19);
        check_fields("R5 no change before commit");
        e_a = a;
        e_n = n;
        commit(1'b0, 1'b0);
        check_fields("R4 divider word");
    endtask

    initial begin
        wait_neg(5);
        check_fields("R1 reset");
        chk("R1 strobes", 32'({ref_valid, div_valid}), 32'd0);
        rst_n = 1'b1;
        wait_neg(3);

        // R2 R3: every mode combination, ratio extremes and random interior
        for (int m = 0; m < 8; m++) begin
            logic [13:0] r;
            if (m == 0)      r = 14'd5;
            else if (m == 7) r = 14'd16383;
            else             r = 14'd5 + 14'(rnd() % 32'd16379);
            do_ref(r, 3'(m), 1'b0);
        end

        // R4 extremes and random interior, interleaved with reference writes (R5)
        do_div(7'd0, 11'd5);
        do_div(7'd127, 11'd2047);
        for (int i = 0; i < 8; i++) begin
            do_div(7'(rnd()), 11'd5 + 11'(rnd() % 32'd2043));
            if (i % 3 == 0) do_ref(14'd5 + 14'(rnd() % 32'd16379), 3'(rnd()), 1'b0);
        end

        // R8: stray leading bit ahead of a reference word
        do_ref(14'h2AAA, 3'b010, 1'b1);
        do_ref(14'h1555, 3'b101, 1'b1);

        // R7: clocks while load enable high are ignored; bare re-commit reloads same word
        do_ref(14'd1000, 3'b011, 1'b0);
        ser_le = 1'b1;
        wait_neg(8);
        send_bits(19'h00000, 4);
        ser_le = 1'b0;
        wait_neg(6);
        commit(1'b1, 1'b1);
        check_fields("R7 ignored clocks");
        commit(1'b1, 1'b0);
        check_fields("R7 re-commit");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule